// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block sits between an interrupt source controller and one processor. It keeps a 32-bit accept word whose upper byte is the processor's current priority threshold and whose lower 24 bits name the source being presented. It also keeps the priority of that presented source and a software inter-processor interrupt (IPI) request level. Numerically lower priority values are more favoured, and 0xFF is the least favoured level. An IPI competes with device sources under a reserved source number.

Each cycle the block applies at most one register-style operation: end-of-interrupt, accept, threshold write or IPI-level write. It then arbitrates an interrupt offered by the source controller, if there is one. A source that loses arbitration, or that a more favoured one displaces, is handed back on a reject strobe. The source controller receives end-of-interrupt and resend-request strobes. A single level output tells the processor that a source is waiting.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the accept word reads 0, the output line is low and no strobe is active. The pending priority and the IPI level both start at 0xFF, so an accept issued right after reset leaves the word at 0xFF000000.
- R2: The accept word holds the threshold in bits 31:24 and the presented source number in bits 23:0. A source field of 0 means nothing is presented. The output line is high exactly when the source field is non-zero.
- R3: An offered interrupt is rejected on the offer reject port in the following cycle in either of two cases. The first is when its priority is greater than or equal to the threshold. The second is when a source is already presented at a priority less than or equal to the offered one.
- R4: An offer that is not rejected becomes the presented source, and its priority is stored. Any source it displaces is reported on the offer reject port.
- R5: An IPI-level write with a value below the threshold makes the reserved IPI source (default 2) the presented source at that priority, and rejects any displaced source on the operation reject port. This does not happen when a source is already presented at a priority less than or equal to the written value.
- R6: An accept lowers the output line and clears the source field. It loads the threshold with the pending priority. The value read in the accept cycle is the word before the operation.
- R7: A threshold write that lowers the threshold loads the new value. If a source is presented at a priority not below the new threshold, that source is cleared, the output line drops and the source is rejected on the operation reject port.
- R8: A threshold write that does not lower the threshold, when nothing is presented, pulses the resend strobe. It also presents the IPI source if the IPI level is below the new threshold.
- R9: An end-of-interrupt with a 32-bit value loads the threshold from bits 31:24 of that value and pulses the EOI strobe carrying bits 23:0. If nothing is presented, it also performs the resend behaviour of R8 against the new threshold.
- R10: When operations coincide, end-of-interrupt wins over accept, accept over threshold write, and threshold write over IPI-level write. Lower-ranked operations are discarded. An offer in the same cycle is arbitrated against the state left by the winning operation.
- R11: The reject, EOI and resend strobes are registered. Each is high for one cycle per event and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eoi_wr_i | input | 1 | End-of-interrupt request |
| eoi_val_i | input | 32 | End-of-interrupt word: threshold and source number |
| ack_rd_i | input | 1 | Accept (read and clear) request |
| prio_wr_i | input | 1 | Threshold write request |
| prio_val_i | input | 8 | New threshold |
| ipi_wr_i | input | 1 | IPI-level write request |
| ipi_val_i | input | 8 | New IPI level |
| offer_vld_i | input | 1 | Interrupt offered by the source controller |
| offer_src_i | input | 24 | Offered source number (non-zero) |
| offer_prio_i | input | 8 | Offered priority |
| irq_o | output | 1 | Interrupt line to the processor |
| ack_data_o | output | 32 | Current accept word |
| rej_op_vld_o | output | 1 | Reject strobe caused by a register operation |
| rej_op_src_o | output | 24 | Source rejected by a register operation |
| rej_ofr_vld_o | output | 1 | Reject strobe caused by offer arbitration |
| rej_ofr_src_o | output | 24 | Source rejected by offer arbitration |
| eoi_vld_o | output | 1 | EOI strobe to the source controller |
| eoi_src_o | output | 24 | Source number carried with the EOI strobe |
| resend_o | output | 1 | Resend request strobe to the source controller |

## Verification
The hardest situation to reach is an IPI that presents itself as a side effect of an end-of-interrupt or a threshold raise. This needs an IPI level parked below the threshold the later operation installs, while nothing is presented. The directed sequence sets this up on purpose: it writes an IPI level, then accepts the IPI so that the threshold falls to its priority, and issues end-of-interrupt and threshold raises from there. A random phase then mixes coinciding operations and offers from a narrow band of priorities. This keeps displacement and ties frequent, and a behavioural model is checked against it every cycle.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_EOI,
    OP_ACK,
    OP_PRIO,
    OP_IPI
  } op_e;
endpackage

// File: rtl/ipr_op_select.sv
module ipr_op_select
  import ipr_pkg::*;
(
  input  logic eoi_wr_i,
  input  logic ack_rd_i,
  input  logic prio_wr_i,
  input  logic ipi_wr_i,
  output op_e  op_o
);
  always_comb begin
    if (eoi_wr_i)       op_o = OP_EOI;
    else if (ack_rd_i)  op_o = OP_ACK;
    else if (prio_wr_i) op_o = OP_PRIO;
    else if (ipi_wr_i)  op_o = OP_IPI;
    else                op_o = OP_NONE;
  end
endmodule

// File: rtl/ipr_op_stage.sv
module ipr_op_stage
  import ipr_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  op_e               op_i,
  input  logic [WORD_W-1:0] eoi_val_i,
  input  logic [PRIO_W-1:0] prio_val_i,
  input  logic [PRIO_W-1:0] ipi_val_i,
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic [PRIO_W-1:0] ipi_lvl_i,
  input  logic              irq_i,
  output logic [PRIO_W-1:0] cppr_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [PRIO_W-1:0] pend_o,
  output logic [PRIO_W-1:0] ipi_lvl_o,
  output logic              irq_o,
  output logic              rej_vld_o,
  output logic [SRC_W-1:0]  rej_src_o,
  output logic              eoi_vld_o,
  output logic [SRC_W-1:0]  eoi_src_o,
  output logic              resend_o
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic busy;
  assign busy = (src_i != '0);

  always_comb begin
    cppr_o    = cppr_i;
    src_o     = src_i;
    pend_o    = pend_i;
    ipi_lvl_o = ipi_lvl_i;
    irq_o     = irq_i;
    rej_vld_o = 1'b0;
    rej_src_o = '0;
    eoi_vld_o = 1'b0;
    eoi_src_o = '0;
    resend_o  = 1'b0;
    unique case (op_i)
      OP_EOI: begin
        cppr_o    = eoi_val_i[WORD_W-1 -: PRIO_W];
        eoi_vld_o = 1'b1;
        eoi_src_o = eoi_val_i[SRC_W-1:0];
        if (!busy) begin
          resend_o = 1'b1;
          // nothing presented, so a qualifying IPI always wins
          if (ipi_lvl_i < eoi_val_i[WORD_W-1 -: PRIO_W]) begin
            src_o  = IPI_NUM;
            pend_o = ipi_lvl_i;
            irq_o  = 1'b1;
          end
        end
      end
      OP_ACK: begin
        cppr_o = pend_i;
        src_o  = '0;
        irq_o  = 1'b0;
      end
      OP_PRIO: begin
        cppr_o = prio_val_i;
        if (prio_val_i < cppr_i) begin
          if (busy && (prio_val_i <= pend_i)) begin
            src_o     = '0;
            irq_o     = 1'b0;
            rej_vld_o = 1'b1;
            rej_src_o = src_i;
          end
        end else if (!busy) begin
          resend_o = 1'b1;
          if (ipi_lvl_i < prio_val_i) begin
            src_o  = IPI_NUM;
            pend_o = ipi_lvl_i;
            irq_o  = 1'b1;
          end
        end
      end
      OP_IPI: begin
        ipi_lvl_o = ipi_val_i;
        if ((ipi_val_i < cppr_i) && !(busy && (pend_i <= ipi_val_i))) begin
          rej_vld_o = busy;
          rej_src_o = busy ? src_i : '0;
          src_o     = IPI_NUM;
          pend_o    = ipi_val_i;
          irq_o     = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ipr_offer_stage.sv
module ipr_offer_stage #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic              vld_i,
  input  logic [SRC_W-1:0]  ofr_src_i,
  input  logic [PRIO_W-1:0] ofr_prio_i,
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic              irq_i,
  output logic [SRC_W-1:0]  src_o,
  output logic [PRIO_W-1:0] pend_o,
  output logic              irq_o,
  output logic              rej_vld_o,
  output logic [SRC_W-1:0]  rej_src_o
);
  logic busy, lose;
  assign busy = (src_i != '0);
  assign lose = (ofr_prio_i >= cppr_i) || (busy && (pend_i <= ofr_prio_i));

  always_comb begin
    src_o     = src_i;
    pend_o    = pend_i;
    irq_o     = irq_i;
    rej_vld_o = 1'b0;
    rej_src_o = '0;
    if (vld_i) begin
      if (lose) begin
        rej_vld_o = 1'b1;
        rej_src_o = ofr_src_i;
      end else begin
        rej_vld_o = busy;
        rej_src_o = busy ? src_i : '0;
        src_o     = ofr_src_i;
        pend_o    = ofr_prio_i;
        irq_o     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
  import ipr_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoi_wr_i,
  input  logic [WORD_W-1:0] eoi_val_i,
  input  logic              ack_rd_i,
  input  logic              prio_wr_i,
  input  logic [PRIO_W-1:0] prio_val_i,
  input  logic              ipi_wr_i,
  input  logic [PRIO_W-1:0] ipi_val_i,
  input  logic              offer_vld_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  output logic              irq_o,
  output logic [WORD_W-1:0] ack_data_o,
  output logic              rej_op_vld_o,
  output logic [SRC_W-1:0]  rej_op_src_o,
  output logic              rej_ofr_vld_o,
  output logic [SRC_W-1:0]  rej_ofr_src_o,
  output logic              eoi_vld_o,
  output logic [SRC_W-1:0]  eoi_src_o,
  output logic              resend_o
);
  localparam logic [PRIO_W-1:0] LEAST = '1;

  logic [PRIO_W-1:0] cppr_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic              irq_q;

  op_e               op;
  logic [PRIO_W-1:0] cppr_m, pend_m, ipi_m, pend_d;
  logic [SRC_W-1:0]  src_m, src_d;
  logic              irq_m, irq_d;
  logic              rop_v, rof_v, eoi_v, rs;
  logic [SRC_W-1:0]  rop_s, rof_s, eoi_s;

  ipr_op_select u_sel (
    .eoi_wr_i (eoi_wr_i),
    .ack_rd_i (ack_rd_i),
    .prio_wr_i(prio_wr_i),
    .ipi_wr_i (ipi_wr_i),
    .op_o     (op)
  );

  ipr_op_stage #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_op (
    .op_i      (op),
    .eoi_val_i (eoi_val_i),
    .prio_val_i(prio_val_i),
    .ipi_val_i (ipi_val_i),
    .cppr_i    (cppr_q),
    .src_i     (src_q),
    .pend_i    (pend_q),
    .ipi_lvl_i (ipi_q),
    .irq_i     (irq_q),
    .cppr_o    (cppr_m),
    .src_o     (src_m),
    .pend_o    (pend_m),
    .ipi_lvl_o (ipi_m),
    .irq_o     (irq_m),
    .rej_vld_o (rop_v),
    .rej_src_o (rop_s),
    .eoi_vld_o (eoi_v),
    .eoi_src_o (eoi_s),
    .resend_o  (rs)
  );

  ipr_offer_stage #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ofr (
    .vld_i     (offer_vld_i),
    .ofr_src_i (offer_src_i),
    .ofr_prio_i(offer_prio_i),
    .cppr_i    (cppr_m),
    .src_i     (src_m),
    .pend_i    (pend_m),
    .irq_i     (irq_m),
    .src_o     (src_d),
    .pend_o    (pend_d),
    .irq_o     (irq_d),
    .rej_vld_o (rof_v),
    .rej_src_o (rof_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q        <= '0;
      src_q         <= '0;
      pend_q        <= LEAST;
      ipi_q         <= LEAST;
      irq_q         <= 1'b0;
      rej_op_vld_o  <= 1'b0;
      rej_op_src_o  <= '0;
      rej_ofr_vld_o <= 1'b0;
      rej_ofr_src_o <= '0;
      eoi_vld_o     <= 1'b0;
      eoi_src_o     <= '0;
      resend_o      <= 1'b0;
    end else begin
      cppr_q        <= cppr_m;
      src_q         <= src_d;
      pend_q        <= pend_d;
      ipi_q         <= ipi_m;
      irq_q         <= irq_d;
      rej_op_vld_o  <= rop_v;
      rej_op_src_o  <= rop_s;
      rej_ofr_vld_o <= rof_v;
      rej_ofr_src_o <= rof_s;
      eoi_vld_o     <= eoi_v;
      eoi_src_o     <= eoi_s;
      resend_o      <= rs;
    end
  end

  assign irq_o      = irq_q;
  assign ack_data_o = {cppr_q, src_q};
endmodule

// File: rtl/ipr_checks.sv
module ipr_checks #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eoi_wr_i,
  input logic [WORD_W-1:0] eoi_val_i,
  input logic              ack_rd_i,
  input logic              prio_wr_i,
  input logic [PRIO_W-1:0] prio_val_i,
  input logic              ipi_wr_i,
  input logic [PRIO_W-1:0] ipi_val_i,
  input logic              offer_vld_i,
  input logic [SRC_W-1:0]  offer_src_i,
  input logic [PRIO_W-1:0] offer_prio_i,
  input logic              irq_o,
  input logic [WORD_W-1:0] ack_data_o,
  input logic              rej_op_vld_o,
  input logic              rej_ofr_vld_o,
  input logic [SRC_W-1:0]  rej_ofr_src_o,
  input logic              eoi_vld_o,
  input logic [SRC_W-1:0]  eoi_src_o
);
  p_irq_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ack_data_o[SRC_W-1:0] != '0));

  p_offer_lose_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_vld_i && !eoi_wr_i && !ack_rd_i && !prio_wr_i && !ipi_wr_i &&
    (offer_prio_i >= ack_data_o[WORD_W-1 -: PRIO_W])
    |=> rej_ofr_vld_o && (rej_ofr_src_o == $past(offer_src_i)));

  p_ipi_win_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_wr_i && !eoi_wr_i && !ack_rd_i && !prio_wr_i && !offer_vld_i &&
    (ack_data_o[SRC_W-1:0] == '0) && (ipi_val_i < ack_data_o[WORD_W-1 -: PRIO_W])
    |=> irq_o && (ack_data_o[SRC_W-1:0] == SRC_W'(IPI_SRC)));

  p_accept_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && !eoi_wr_i && !offer_vld_i
    |=> !irq_o && (ack_data_o[SRC_W-1:0] == '0));

  p_prio_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_wr_i && !eoi_wr_i && !ack_rd_i
    |=> ack_data_o[WORD_W-1 -: PRIO_W] == $past(prio_val_i));

  // R7, R5: only threshold or IPI writes reject through the operation port
  p_op_reject_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_op_vld_o |-> $past(prio_wr_i || ipi_wr_i));

  p_eoi_fwd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr_i |=> eoi_vld_o && (eoi_src_o == $past(eoi_val_i[SRC_W-1:0])) &&
    (ack_data_o[WORD_W-1 -: PRIO_W] == $past(eoi_val_i[WORD_W-1 -: PRIO_W])));
endmodule

bind intr_present_unit ipr_checks #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eoi_wr_i     (eoi_wr_i),
  .eoi_val_i    (eoi_val_i),
  .ack_rd_i     (ack_rd_i),
  .prio_wr_i    (prio_wr_i),
  .prio_val_i   (prio_val_i),
  .ipi_wr_i     (ipi_wr_i),
  .ipi_val_i    (ipi_val_i),
  .offer_vld_i  (offer_vld_i),
  .offer_src_i  (offer_src_i),
  .offer_prio_i (offer_prio_i),
  .irq_o        (irq_o),
  .ack_data_o   (ack_data_o),
  .rej_op_vld_o (rej_op_vld_o),
  .rej_ofr_vld_o(rej_ofr_vld_o),
  .rej_ofr_src_o(rej_ofr_src_o),
  .eoi_vld_o    (eoi_vld_o),
  .eoi_src_o    (eoi_src_o)
);

// File: tb/sim_intr_present_unit.sv
`timescale 1ns/1ps
module sim_intr_present_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eoi_wr_i = 0, ack_rd_i = 0, prio_wr_i = 0, ipi_wr_i = 0, offer_vld_i = 0;
  logic [31:0] eoi_val_i = '0;
  logic [7:0]  prio_val_i = '0, ipi_val_i = '0, offer_prio_i = '0;
  logic [23:0] offer_src_i = '0;
  logic        irq_o, rej_op_vld_o, rej_ofr_vld_o, eoi_vld_o, resend_o;
  logic [31:0] ack_data_o;
  logic [23:0] rej_op_src_o, rej_ofr_src_o, eoi_src_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  intr_present_unit u0 (.*);

  // behavioural reference
  int m_thr, m_src, m_pend, m_ipi;
  int e_rop_v, e_rop_s, e_rof_v, e_rof_s, e_eoi_v, e_eoi_s, e_rs;

  task automatic m_present_ipi();
    m_src = 2; m_pend = m_ipi;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_thr = 0; m_src = 0; m_pend = 255; m_ipi = 255;
      e_rop_v = 0; e_rop_s = 0; e_rof_v = 0; e_rof_s = 0;
      e_eoi_v = 0; e_eoi_s = 0; e_rs = 0;
    end else begin
      int old_thr;
      e_rop_v = 0; e_rop_s = 0; e_rof_v = 0; e_rof_s = 0;
      e_eoi_v = 0; e_eoi_s = 0; e_rs = 0;
      old_thr = m_thr;
      if (eoi_wr_i) begin
        m_thr = int'(eoi_val_i[31:24]);
        e_eoi_v = 1; e_eoi_s = int'(eoi_val_i[23:0]);
        if (m_src == 0) begin
          e_rs = 1;
          if (m_ipi < m_thr) m_present_ipi();
        end
      end else if (ack_rd_i) begin
        m_thr = m_pend; m_src = 0;
      end else if (prio_wr_i) begin
        m_thr = int'(prio_val_i);
        if (m_thr < old_thr) begin
          if (m_src != 0 && m_thr <= m_pend) begin
            e_rop_v = 1; e_rop_s = m_src; m_src = 0;
          end
        end else if (m_src == 0) begin
          e_rs = 1;
          if (m_ipi < m_thr) m_present_ipi();
        end
      end else if (ipi_wr_i) begin
        m_ipi = int'(ipi_val_i);
        if (m_ipi < m_thr) begin
          if (m_src == 0 || m_pend > m_ipi) begin
            if (m_src != 0) begin e_rop_v = 1; e_rop_s = m_src; end
            m_present_ipi();
          end
        end
      end
      if (offer_vld_i) begin
        int p, s;
        p = int'(offer_prio_i); s = int'(offer_src_i);
        if (p >= m_thr || (m_src != 0 && m_pend <= p)) begin
          e_rof_v = 1; e_rof_s = s;
        end else begin
          if (m_src != 0) begin e_rof_v = 1; e_rof_s = m_src; end
          m_src = s; m_pend = p;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2 word", ack_data_o, {m_thr[7:0], m_src[23:0]});
      chk("R2 line", {31'd0, irq_o}, {31'd0, m_src != 0});
      chk("R11 op reject", {7'd0, rej_op_vld_o, rej_op_src_o}, {7'd0, e_rop_v[0], e_rop_s[23:0]});
      chk("R11 offer reject", {7'd0, rej_ofr_vld_o, rej_ofr_src_o}, {7'd0, e_rof_v[0], e_rof_s[23:0]});
      chk("R11 eoi", {7'd0, eoi_vld_o, eoi_src_o}, {7'd0, e_eoi_v[0], e_eoi_s[23:0]});
      chk("R11 resend", {31'd0, resend_o}, {31'd0, e_rs[0]});
    end
  end

  task automatic clr();
    eoi_wr_i = 0; ack_rd_i = 0; prio_wr_i = 0; ipi_wr_i = 0; offer_vld_i = 0;
  endtask
  task automatic step();
    @(negedge clk_i); #0.5; clr();
  endtask
  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    offer_vld_i = 1; offer_src_i = s; offer_prio_i = p;
  endtask
  task automatic wprio(input logic [7:0] v); prio_wr_i = 1; prio_val_i = v; endtask
  task automatic wipi(input logic [7:0] v);  ipi_wr_i = 1; ipi_val_i = v; endtask
  task automatic weoi(input logic [31:0] v); eoi_wr_i = 1; eoi_val_i = v; endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #0.5;
    chk("R1 reset word", ack_data_o, 32'h0);
    chk("R1 reset line", {31'd0, irq_o}, 32'd0);
    ack_rd_i = 1; step();
    chk("R1 pending FF after accept", ack_data_o, 32'hFF00_0000);
    wprio(8'h80); step();
    wprio(8'hC0); step();
    chk("R8 resend on raise", {31'd0, resend_o}, 32'd1);
    wprio(8'h80); step();
    offer(24'h100, 8'h40); step();
    chk("R4 offer presented", ack_data_o, 32'h8000_0100);
    chk("R2 line high", {31'd0, irq_o}, 32'd1);
    offer(24'h200, 8'h40); step();
    chk("R3 tie rejected", {7'd0, rej_ofr_vld_o, rej_ofr_src_o}, {8'h01, 24'h200});
    offer(24'h300, 8'h90); step();
    chk("R3 above threshold rejected", {7'd0, rej_ofr_vld_o, rej_ofr_src_o}, {8'h01, 24'h300});
    offer(24'h400, 8'h10); step();
    chk("R4 displaced rejected", {7'd0, rej_ofr_vld_o, rej_ofr_src_o}, {8'h01, 24'h100});
    chk("R4 new source", ack_data_o, 32'h8000_0400);
    wipi(8'h20); step();
    chk("R5 IPI loses", {7'd0, rej_op_vld_o, 24'd0}, 32'd0);
    chk("R5 word kept", ack_data_o, 32'h8000_0400);
    wipi(8'h05); step();
    chk("R5 IPI displaces", {7'd0, rej_op_vld_o, rej_op_src_o}, {8'h01, 24'h400});
    chk("R5 IPI presented", ack_data_o, 32'h8000_0002);
    ack_rd_i = 1; step();
    chk("R6 accept reload", ack_data_o, 32'h0500_0000);
    chk("R6 line low", {31'd0, irq_o}, 32'd0);
    weoi(32'h8000_0002); step();
    chk("R9 eoi strobe", {7'd0, eoi_vld_o, eoi_src_o}, {8'h01, 24'h2});
    chk("R9 resend and IPI", {resend_o, ack_data_o[30:0]}, {1'b1, 31'h0000_0002});
    wprio(8'h03); step();
    chk("R7 lower rejects", {7'd0, rej_op_vld_o, rej_op_src_o}, {8'h01, 24'h2});
    chk("R7 word", ack_data_o, 32'h0300_0000);
    wprio(8'h06); step();
    chk("R8 raise presents IPI", ack_data_o, 32'h0600_0002);
    weoi(32'h4000_0000); ack_rd_i = 1; wprio(8'h01); wipi(8'h01); step();
    chk("R10 eoi wins", ack_data_o, 32'h4000_0002);
    ack_rd_i = 1; wprio(8'hFF); offer(24'h500, 8'h03); step();
    chk("R10 accept then offer", ack_data_o, 32'h0500_0500);
    step();
    chk("R11 strobes idle", {eoi_vld_o, rej_op_vld_o, rej_ofr_vld_o, resend_o}, 4'd0);
    // mixed random traffic, model compared each cycle
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0) weoi({8'($urandom_range(0, 15)), 24'($urandom_range(0, 7))});
      if (k == 1 || k == 7) ack_rd_i = 1;
      if (k == 2 || k == 8) wprio(8'($urandom_range(0, 15)));
      if (k == 3 || k == 7) wipi(8'($urandom_range(0, 15)));
      if ($urandom_range(0, 1) == 1) offer(24'($urandom_range(1, 9)), 8'($urandom_range(0, 15)));
      step();
    end
    finish_run();
  end
endmodule